// File: doc/BRIEF.md
# Auxiliary Converter Channel Sequencer

This block schedules conversions for a bank of up to six auxiliary analog-to-digital channels that share one converter. A write-only enable mask chooses which channels take part. A second control register holds a rate select, a continuous-mode bit and a self-clearing start bit. The sequencer gives each enabled channel a fixed conversion window, in ascending channel order. At the start of each window it issues a convert strobe and the channel index. Inside the window it supplies a converter clock-enable tick. At the close of the window it issues a one-hot result-valid pulse together with the result that the converter returned.

There are two states. `SEQ_IDLE` waits for a start request or for continuous mode. `SEQ_CONV` counts one channel window. The transitions are:
- *launch*: `SEQ_IDLE` to `SEQ_CONV`, taken when the mask holds an enabled channel.
- *empty-close*: stay in `SEQ_IDLE` and clear the start bit, taken when the mask is empty.
- *advance*: `SEQ_CONV` to `SEQ_CONV` on the next higher enabled channel.
- *wrap*: `SEQ_CONV` to `SEQ_CONV` on the lowest enabled channel, in continuous mode only.
- *finish*: `SEQ_CONV` to `SEQ_IDLE`, which clears the start bit in single-shot mode.

Top module: `aux_adc_sequencer`

## Requirements
- R1: The enable register maps bit i (i = 0..5) to channel i. Bits 7:6 of a write have no effect. Written with 0xC0, a start completes with no conversion.
- R2: Within a pass, channels are converted in ascending index order. Disabled channels are skipped with no window spent on them, so consecutive convert strobes are exactly one window apart.
- R3: A window lasts 176 clocks when control bit 2 is 0 and 352 clocks when it is 1. The rate is sampled when the window starts.
- R4: A converter clock-enable tick occurs every 16 clocks, or every 32 clocks at the slow rate, only inside a window. That gives 11 ticks per window, and the last tick falls on the window's final cycle.
- R5: Writing control bit 0 = 1 (with bit 1 = 0) sets the start flag and converts each enabled channel once. The flag reads 0 on the cycle after the last window's final cycle.
- R6: A control write with bit 1 = 1 leaves the start flag at 0, whatever bit 0 holds.
- R7: With bit 1 = 1, passes repeat back to back with no gap. With an empty mask the block stays idle until a channel is enabled. Clearing bit 1 lets the current pass finish and then stops.
- R8: The mask is read when a channel's turn comes. A mask change during a window does not shorten that window, and it governs which later channels are converted.
- R9: A single-shot start with an empty mask clears the start flag one cycle after it was set and issues no strobe.
- R10: One cycle after each window's final cycle, `res_valid` is one-hot on the window's channel. `res_data` then carries the last value presented with `cvt_done` during that window.
- R11: After reset the block is idle, all strobes and flags are 0, and the mask and control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 8 | Enable mask write data, bits 5:0 used |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control data: bit 2 rate, bit 1 continuous, bit 0 start |
| cvt_done | input | 1 | Converter result-ready pulse |
| cvt_data | input | 10 | Converter result |
| cvt_strobe | output | 1 | One-cycle convert request at window start |
| cvt_chan | output | 3 | Channel being converted |
| cvt_clk_en | output | 1 | Converter clock-enable tick |
| busy | output | 1 | A window is in progress |
| start_flag | output | 1 | Start bit readback, cleared by hardware |
| res_valid | output | 6 | One-hot result-valid pulse per channel |
| res_data | output | 10 | Result belonging to the pulsed channel |

## Verification
The scoreboard is fed a sparse mask (0xED), which exposes ordering and skipping errors. A two-channel slow-rate mask separates the 176-clock window from the 352-clock window. A mask rewritten in the middle of a window shows whether a window is aborted or the mask is sampled too early. Two continuous passes over channels 2 and 5 expose wrap faults. An empty mask and a mask of only the upper bits show the empty-close and continuous-idle transitions. Each result pulse is compared with a channel-dependent value from the bench's converter model, which catches results attached to the wrong channel.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_t;

    localparam int CTL_START_BIT = 0;
    localparam int CTL_CONT_BIT  = 1;
    localparam int CTL_RATE_BIT  = 2;
endpackage

// File: rtl/aux_seq_regs.sv
module aux_seq_regs
    import aux_seq_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [REG_W-1:0]  en_wdata,
    input  logic              ctl_wr,
    input  logic [REG_W-1:0]  ctl_wdata,
    input  logic              clr_start,
    output logic [NUM_CH-1:0] en_mask,
    output logic              rate_slow,
    output logic              cont_mode,
    output logic              start_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mask <= '0;
        end else if (en_wr) begin
            en_mask <= en_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_slow <= 1'b0;
            cont_mode <= 1'b0;
            start_q   <= 1'b0;
        end else if (ctl_wr) begin
            rate_slow <= ctl_wdata[CTL_RATE_BIT];
            cont_mode <= ctl_wdata[CTL_CONT_BIT];
            start_q   <= ctl_wdata[CTL_START_BIT] & ~ctl_wdata[CTL_CONT_BIT];
        end else if (clr_start) begin
            start_q   <= 1'b0;
        end
    end

    AST_START_NOT_IN_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cont_mode) |-> !start_q); // R6
endmodule

// File: rtl/aux_seq_timer.sv
module aux_seq_timer #(
    parameter int DIV_LOG2 = 4,
    parameter int TICKS    = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic slow_in,
    input  logic run,
    output logic tick,
    output logic win_end
);
    localparam int LEN_FAST = TICKS << DIV_LOG2;
    localparam int LEN_SLOW = 2 * LEN_FAST;
    localparam int CNT_W    = $clog2(LEN_SLOW);

    logic [CNT_W-1:0] cnt_q;
    logic             slow_q;
    logic [CNT_W-1:0] last_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slow_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= '0;
            slow_q <= slow_in;
        end else if (run) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign last_cnt = slow_q ? CNT_W'(LEN_SLOW - 1) : CNT_W'(LEN_FAST - 1);
    assign tick     = run && (slow_q ? (&cnt_q[DIV_LOG2:0]) : (&cnt_q[DIV_LOG2-1:0]));
    assign win_end  = run && (cnt_q == last_cnt);

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CNT_W'(LEN_SLOW))); // R3
    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (run && win_end && !load) |=> !run); // R7
endmodule

// File: rtl/aux_seq_picker.sv
module aux_seq_picker #(
    parameter int NUM_CH = 6,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [IDX_W-1:0]  base,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    logic [NUM_CH-1:0] qual;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_qual
        assign qual[g] = mask[g] && (IDX_W'(g) >= base);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (qual[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/aux_adc_sequencer.sv
module aux_adc_sequencer
    import aux_seq_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int REG_W    = 8,
    parameter int DATA_W   = 10,
    parameter int DIV_LOG2 = 4,
    parameter int TICKS    = 11,
    parameter int IDX_W    = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [REG_W-1:0]  en_wdata,
    input  logic              ctl_wr,
    input  logic [REG_W-1:0]  ctl_wdata,
    input  logic              cvt_done,
    input  logic [DATA_W-1:0] cvt_data,
    output logic              cvt_strobe,
    output logic [IDX_W-1:0]  cvt_chan,
    output logic              cvt_clk_en,
    output logic              busy,
    output logic              start_flag,
    output logic [NUM_CH-1:0] res_valid,
    output logic [DATA_W-1:0] res_data
);
    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  cur_q, cur_d;
    logic [NUM_CH-1:0] en_mask;
    logic              rate_slow, cont_mode, start_q, clr_start;
    logic              load, tick, win_end;
    logic              hit_head, hit_next;
    logic [IDX_W-1:0]  idx_head, idx_next;
    logic [DATA_W-1:0] hold_q;

    aux_seq_regs #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .clr_start(clr_start),
        .en_mask(en_mask), .rate_slow(rate_slow),
        .cont_mode(cont_mode), .start_q(start_q)
    );

    aux_seq_timer #(.DIV_LOG2(DIV_LOG2), .TICKS(TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(load), .slow_in(rate_slow),
        .run(state_q == SEQ_CONV),
        .tick(tick), .win_end(win_end)
    );

    aux_seq_picker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick_head (
        .mask(en_mask), .base('0), .found(hit_head), .idx(idx_head)
    );

    aux_seq_picker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick_next (
        .mask(en_mask), .base(cur_q + 1'b1), .found(hit_next), .idx(idx_next)
    );

    // Transition logic
    always_comb begin
        state_d   = state_q;
        cur_d     = cur_q;
        load      = 1'b0;
        clr_start = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (cont_mode || start_q) begin
                    if (hit_head) begin           // launch
                        state_d = SEQ_CONV;
                        cur_d   = idx_head;
                        load    = 1'b1;
                    end else if (!cont_mode) begin // empty-close
                        clr_start = 1'b1;
                    end
                end
            end
            SEQ_CONV: begin
                if (win_end) begin
                    if (hit_next) begin           // advance
                        cur_d = idx_next;
                        load  = 1'b1;
                    end else if (cont_mode && hit_head) begin // wrap
                        cur_d = idx_head;
                        load  = 1'b1;
                    end else begin                // finish
                        state_d   = SEQ_IDLE;
                        clr_start = !cont_mode;
                    end
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cvt_strobe <= 1'b0;
            res_valid  <= '0;
            res_data   <= '0;
            hold_q     <= '0;
        end else begin
            cvt_strobe <= load;
            if (state_q == SEQ_CONV && cvt_done) begin
                hold_q <= cvt_data;
            end
            if (state_q == SEQ_CONV && win_end) begin
                res_valid <= NUM_CH'(1) << cur_q;
                res_data  <= cvt_done ? cvt_data : hold_q;
            end else begin
                res_valid <= '0;
            end
        end
    end

    assign cvt_chan   = cur_q;
    assign cvt_clk_en = tick;
    assign busy       = (state_q == SEQ_CONV);
    assign start_flag = start_q;

    AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_valid)); // R10
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_strobe |-> busy); // R2
    AST_STROBE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_strobe |-> ((($past(en_mask) >> cvt_chan) & NUM_CH'(1)) != '0)); // R8
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cvt_clk_en); // R4
    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cvt_chan < IDX_W'(NUM_CH))); // R2
endmodule

// File: tb/aux_adc_sequencer_tb.sv
`timescale 1ns/1ps
module aux_adc_sequencer_tb;
    localparam int PER = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 1'b0, ctl_wr = 1'b0, cvt_done = 1'b0;
    logic [7:0] en_wdata = '0, ctl_wdata = '0;
    logic [9:0] cvt_data = '0;
    logic       cvt_strobe, cvt_clk_en, busy, start_flag;
    logic [2:0] cvt_chan;
    logic [5:0] res_valid;
    logic [9:0] res_data;

    aux_adc_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cvt_done(cvt_done), .cvt_data(cvt_data),
        .cvt_strobe(cvt_strobe), .cvt_chan(cvt_chan),
        .cvt_clk_en(cvt_clk_en), .busy(busy),
        .start_flag(start_flag),
        .res_valid(res_valid), .res_data(res_data)
    );

    always #(PER/2) clk = ~clk;

    typedef struct { int chan; int gap; } exp_t;
    exp_t exp_q[$];
    int   n_cmp = 0, n_bad = 0, n_res = 0;
    time  last_t = 0;
    int   pend_chan = 0, tick_cnt = 0, model_cd = 0, model_ch = 0;

    function automatic logic [9:0] model_val(int ch);
        return 10'(ch * 97 + 13);
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push_exp(int ch, int gap);
        exp_t e;
        e.chan = ch;
        e.gap = gap;
        exp_q.push_back(e);
    endtask

    task automatic wr_en(logic [7:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic wr_ctl(logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wait_start_low();
        while (start_flag) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor, scoreboard and converter model
    initial begin
        forever begin
            @(negedge clk);
            cvt_done = 1'b0;
            if (model_cd > 0) begin
                model_cd--;
                if (model_cd == 0) begin
                    cvt_done = 1'b1;
                    cvt_data = model_val(model_ch);
                end
            end
            if (rst_n) begin
                if (res_valid != 0) begin
                    n_res++;
                    chk(res_valid == (6'd1 << pend_chan), "R10 onehot", int'(res_valid), 1 << pend_chan);
                    chk(res_data == model_val(pend_chan), "R10 data", int'(res_data), int'(model_val(pend_chan)));
                end
                if (cvt_clk_en) tick_cnt++;
                if (cvt_strobe) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected strobe", int'(cvt_chan), -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(int'(cvt_chan) == e.chan, "R2 channel order", int'(cvt_chan), e.chan);
                        if (e.gap != 0) begin
                            chk(int'(($time - last_t) / PER) == e.gap, "R3 window length",
                                int'(($time - last_t) / PER), e.gap);
                            chk(tick_cnt == 11, "R4 ticks per window", tick_cnt, 11);
                        end
                    end
                    last_t    = $time;
                    tick_cnt  = 0;
                    pend_chan = int'(cvt_chan);
                    model_ch  = int'(cvt_chan);
                    model_cd  = 100;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !cvt_strobe && !start_flag && res_valid == 0 && !cvt_clk_en,
            "R11 reset state", int'({busy, cvt_strobe, start_flag}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: empty mask single shot
        wr_ctl(8'h01);
        chk(start_flag == 1'b1, "R9 start set", int'(start_flag), 1);
        @(negedge clk);
        chk(start_flag == 1'b0, "R9 start cleared", int'(start_flag), 0);
        repeat (5) @(negedge clk);

        // R1: only upper bits written -> no channel enabled
        wr_en(8'hC0);
        wr_ctl(8'h01);
        @(negedge clk);
        chk(start_flag == 1'b0 && !busy, "R1 upper bits ignored", int'(busy), 0);
        repeat (5) @(negedge clk);

        // R2 R3 R4 R5: sparse mask, fast rate
        wr_en(8'hED);
        push_exp(0, 0); push_exp(2, 176); push_exp(3, 176); push_exp(5, 176);
        wr_ctl(8'h01);
        wait_start_low();
        chk(int'(($time - last_t) / PER) == 176, "R5 start clears at pass end",
            int'(($time - last_t) / PER), 176);
        chk(!busy, "R5 idle after pass", int'(busy), 0);
        chk(exp_q.size() == 0, "R2 pass complete", exp_q.size(), 0);

        // R3: slow rate
        wr_en(8'h12);
        push_exp(1, 0); push_exp(4, 352);
        wr_ctl(8'h05);
        wait_start_low();
        chk(int'(($time - last_t) / PER) == 352, "R3 slow last window",
            int'(($time - last_t) / PER), 352);

        // R8: mask rewrite mid-window
        wr_ctl(8'h00);
        wr_en(8'h03);
        push_exp(0, 0); push_exp(2, 176);
        wr_ctl(8'h01);
        repeat (20) @(negedge clk);
        wr_en(8'h04);
        wait_start_low();
        chk(exp_q.size() == 0, "R8 mask sampled per turn", exp_q.size(), 0);

        // R6 R7: continuous mode
        wr_en(8'h24);
        push_exp(2, 0); push_exp(5, 176); push_exp(2, 176); push_exp(5, 176);
        wr_ctl(8'h03);
        chk(start_flag == 1'b0, "R6 start ignored in continuous", int'(start_flag), 0);
        while (exp_q.size() != 0) @(negedge clk);
        wr_ctl(8'h00);
        wait_idle();
        chk(exp_q.size() == 0, "R7 stop after pass", exp_q.size(), 0);

        // R7: continuous idle on empty mask
        wr_en(8'h00);
        wr_ctl(8'h02);
        repeat (50) @(negedge clk);
        chk(!busy, "R7 idle with empty mask", int'(busy), 0);
        push_exp(0, 0);
        wr_en(8'h01);
        while (exp_q.size() != 0) @(negedge clk);
        wr_ctl(8'h00);
        wait_idle();
        repeat (3) @(negedge clk);
        chk(n_res == 13, "R10 result pulse count", n_res, 13);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule